// File: doc/BRIEF.md
# Receive Byte Buffer with Character-Count and Idle Events

This block is a deep byte queue placed between the receiver of a serial controller and a host register port. Bytes arrive as a stream from one of two receiver channels, and a control bit selects the channel. The host takes bytes out by reading a data register. Software can leave per-character interrupts turned off and still learn when a message has ended. For that, the block raises one interrupt line for three causes: the queue has reached half its depth, a chosen character has arrived a chosen number of times, or data has been waiting with no traffic for a programmed number of clock cycles.

Each input channel has a valid/ready pair. Only the selected channel sees ready, and it sees it only while the buffer path is enabled. The unselected channel never gets ready, and its valid is ignored. Ready does not fall when the queue is full. A byte offered to a full queue is accepted at the handshake and then discarded, and a sticky overflow flag records the loss. Back-pressure therefore means only "path disabled or channel not selected". An upstream sender that must not lose data has to watch the full or half-full status.

The host port is a plain register strobe interface. Writes take effect at the clock edge. Read data is combinational from the address. A read strobe on the data address removes one byte.

Top module: `rx_byte_buffer`

## Requirements
- R1: After reset, and in the cycle after the enable bit (control bit 0) is written 0, the queue is empty, overflow and both events are clear, `irq` is low and neither channel sees ready. Status then reads 0x01.
- R2: Control bit 1 selects the source: 0 takes channel A and 1 takes channel B. Only the selected channel sees ready. Bytes offered on the other channel are not stored.
- R3: Bytes come out in arrival order. The half flag (status bit 1) is set while the queue holds at least DEPTH/2 bytes. The full flag (status bit 2) is set at DEPTH bytes.
- R4: A data read from an empty queue returns the most recently removed byte and removes nothing. The next stored byte is the next one read.
- R5: A byte offered to a full queue is discarded and sets the overflow flag (status bit 3). The flag stays set until writing 1 to control bit 6, which empties the queue and reads back as 0.
- R6: With pattern detection on (control bit 3), the pattern event (status bit 4) sets on the N-th stored byte that equals the pattern character. N is the pattern count register, and 0 acts as 1. The counter then reloads from N.
- R7: With the idle timer on (control bit 2) and a nonzero timeout value T, the idle event (status bit 5) sets once the queue has been non-empty with no byte stored or removed for T+1 cycles. Any store or removal restarts the interval. The event never sets while the queue is empty.
- R8: `irq` is high when any of these holds: half flag with control bit 4 set, idle event, or pattern event. The idle and pattern events stay set until a byte is removed or the queue is reset.
- R9: Writing 1 to control bit 7 gives a single-cycle `tx_clear` pulse in the cycle after the write. Both reset bits read back as 0.

Register addresses: 0 data, 1 control, 2 status (bit 0 empty), 3 pattern character, 4 pattern count, 5 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_valid | input | 1 | Channel A byte offered |
| a_data | input | DW | Channel A byte |
| a_ready | output | 1 | Channel A accepted |
| b_valid | input | 1 | Channel B byte offered |
| b_data | input | DW | Channel B byte |
| b_ready | output | 1 | Channel B accepted |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a byte at address 0) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| irq | output | 1 | Receive interrupt |
| tx_clear | output | 1 | One-cycle transmit-queue reset pulse |

## Verification
The queue is tested with a short mixed sequence to check ordering, with a complete fill to find the exact byte count at which the half and full flags turn on, and with one byte pushed past full to show that a dropped byte leaves the stored bytes intact. The pattern counter is given matching and non-matching bytes interleaved: this shows that only matches count, and a second round shows that the counter reloads after it fires. The idle timer is tried with an undisturbed wait, with a wait broken by a new byte, and with an empty queue; together these separate restart-on-traffic from never-fire-when-empty. Bytes on the unselected channel and reads from an empty queue show that ignored stimulus changes nothing.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_STAT = 3'd2;
  localparam logic [2:0] ADR_PCHR = 3'd3;
  localparam logic [2:0] ADR_PCNT = 3'd4;
  localparam logic [2:0] ADR_TOUT = 3'd5;

  localparam int C_EN    = 0;
  localparam int C_SRCB  = 1;
  localparam int C_TOEN  = 2;
  localparam int C_PATEN = 3;
  localparam int C_HFEN  = 4;
  localparam int C_RXRST = 6;
  localparam int C_TXRST = 7;

  localparam int S_EMPTY = 0;
  localparam int S_HALF  = 1;
  localparam int S_FULL  = 2;
  localparam int S_OVF   = 3;
  localparam int S_PAT   = 4;
  localparam int S_IDLE  = 5;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [DW-1:0]               din,
  input  logic                        pop,
  output logic [DW-1:0]               dout,
  output logic                        taken,
  output logic [$clog2(DEPTH):0]      count,
  output logic                        empty,
  output logic                        full,
  output logic                        half,
  output logic                        ovf
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [DW-1:0] last;
  logic          pop_ok;

  assign empty  = (count == '0);
  assign full   = (count == CNTW'(DEPTH));
  assign half   = (count >= CNTW'(DEPTH / 2));
  assign pop_ok = pop && !empty;
  assign taken  = push && (!full || pop_ok);
  assign dout   = empty ? last : mem[rp];

  always_ff @(posedge clk) begin
    if (taken) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0; last <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0;
    end else begin
      if (taken) wp <= wp + 1'b1;
      if (pop_ok) begin
        rp   <= rp + 1'b1;
        last <= mem[rp];
      end
      case ({taken, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full && !pop_ok) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxbuf_match.sv
module rxbuf_match #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] load_val,
  input  logic          hit,
  input  logic          ack,
  output logic          evt
);
  logic [CW-1:0] left;
  logic          fire;

  assign fire = hit && (left <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0; evt <= 1'b0;
    end else if (clr) begin
      left <= load_val; evt <= 1'b0;
    end else begin
      if (hit) left <= fire ? load_val : left - 1'b1;
      if (fire)     evt <= 1'b1;
      else if (ack) evt <= 1'b0;
    end
  end
endmodule

// File: rtl/rxbuf_idle.sv
module rxbuf_idle #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          empty,
  input  logic          activity,
  input  logic          ack,
  input  logic [TW-1:0] limit,
  output logic          evt
);
  logic [TW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= '0; evt <= 1'b0;
    end else if (clr) begin
      idle <= '0; evt <= 1'b0;
    end else begin
      if (empty || activity)  idle <= '0;
      else if (idle != limit) idle <= idle + 1'b1;
      if (ack) evt <= 1'b0;
      else if (!empty && !activity && limit != '0 && idle == limit) evt <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  output logic          a_ready,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          b_ready,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          tx_clear
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic          ctrl_en, ctrl_srcb, ctrl_toen, ctrl_paten, ctrl_hfen;
  logic [DW-1:0] pat_chr, pat_num, to_lim;
  logic          wr_ctrl, rx_rst, clr_all;
  logic          push_req, rd_data_req, pop_req;
  logic [DW-1:0] sel_data, fifo_dout;
  logic          fifo_taken, fifo_empty, fifo_full, fifo_half, fifo_ovf;
  logic [CNTW-1:0] fifo_count;
  logic          pat_evt, to_evt, pat_hit;

  assign wr_ctrl     = reg_wr && (reg_addr == ADR_CTRL);
  assign rx_rst      = wr_ctrl && reg_wdata[C_RXRST];
  assign clr_all     = !ctrl_en || rx_rst;
  assign a_ready     = ctrl_en && !ctrl_srcb;
  assign b_ready     = ctrl_en && ctrl_srcb;
  assign push_req    = (a_valid && a_ready) || (b_valid && b_ready);
  assign sel_data    = ctrl_srcb ? b_data : a_data;
  assign rd_data_req = reg_rd && (reg_addr == ADR_DATA);
  assign pop_req     = rd_data_req && ctrl_en;
  assign pat_hit     = fifo_taken && ctrl_paten && (sel_data == pat_chr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_srcb <= 1'b0; ctrl_toen <= 1'b0;
      ctrl_paten <= 1'b0; ctrl_hfen <= 1'b0; tx_clear <= 1'b0;
      pat_chr <= '0; pat_num <= '0; to_lim <= '0;
    end else begin
      tx_clear <= wr_ctrl && reg_wdata[C_TXRST];
      if (wr_ctrl) begin
        ctrl_en    <= reg_wdata[C_EN];
        ctrl_srcb  <= reg_wdata[C_SRCB];
        ctrl_toen  <= reg_wdata[C_TOEN];
        ctrl_paten <= reg_wdata[C_PATEN];
        ctrl_hfen  <= reg_wdata[C_HFEN];
      end
      if (reg_wr && reg_addr == ADR_PCHR) pat_chr <= reg_wdata;
      if (reg_wr && reg_addr == ADR_PCNT) pat_num <= reg_wdata;
      if (reg_wr && reg_addr == ADR_TOUT) to_lim  <= reg_wdata;
    end
  end

  rxbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .push(push_req), .din(sel_data),
    .pop(pop_req), .dout(fifo_dout), .taken(fifo_taken), .count(fifo_count),
    .empty(fifo_empty), .full(fifo_full), .half(fifo_half), .ovf(fifo_ovf)
  );

  rxbuf_match #(.CW(DW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_all || !ctrl_paten || (reg_wr && reg_addr == ADR_PCNT)),
    .load_val(reg_wr && reg_addr == ADR_PCNT ? reg_wdata : pat_num),
    .hit(pat_hit), .ack(pop_req && !fifo_empty), .evt(pat_evt)
  );

  rxbuf_idle #(.TW(DW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(clr_all || !ctrl_toen), .empty(fifo_empty),
    .activity(fifo_taken || (pop_req && !fifo_empty)),
    .ack(pop_req && !fifo_empty), .limit(to_lim), .evt(to_evt)
  );

  assign irq = (ctrl_hfen && fifo_half) || to_evt || pat_evt;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_DATA: reg_rdata = fifo_dout;
      ADR_CTRL: begin
        reg_rdata[C_EN]    = ctrl_en;
        reg_rdata[C_SRCB]  = ctrl_srcb;
        reg_rdata[C_TOEN]  = ctrl_toen;
        reg_rdata[C_PATEN] = ctrl_paten;
        reg_rdata[C_HFEN]  = ctrl_hfen;
      end
      ADR_STAT: begin
        reg_rdata[S_EMPTY] = fifo_empty;
        reg_rdata[S_HALF]  = fifo_half;
        reg_rdata[S_FULL]  = fifo_full;
        reg_rdata[S_OVF]   = fifo_ovf;
        reg_rdata[S_PAT]   = pat_evt;
        reg_rdata[S_IDLE]  = to_evt;
      end
      ADR_PCHR: reg_rdata = pat_chr;
      ADR_PCNT: reg_rdata = pat_num;
      ADR_TOUT: reg_rdata = to_lim;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int DEPTH = 1024
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    rx_rst,
  input logic [$clog2(DEPTH):0]  count,
  input logic                    full,
  input logic                    empty,
  input logic                    ovf,
  input logic                    to_evt,
  input logic                    irq,
  input logic                    push_req,
  input logic                    pop_req,
  input logic                    rd_data_req
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));                                               // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    en && full && push_req && !pop_req && !rx_rst |=> $stable(count));    // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en && ovf && !rx_rst |=> ovf);                                        // R5
  AST_EMPTY_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !to_evt);                                                   // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);                                                        // R1
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_data_req && !push_req |=> count == '0);                   // R4
endmodule

bind rx_byte_buffer rxbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .rx_rst(rx_rst), .count(fifo_count),
  .full(fifo_full), .empty(fifo_empty), .ovf(fifo_ovf), .to_evt(to_evt),
  .irq(irq), .push_req(push_req), .pop_req(pop_req), .rd_data_req(rd_data_req)
);

// File: tb/sim_rx_byte_buffer.sv
`timescale 1ns/1ps
module sim_rx_byte_buffer;
  localparam int DEPTH = 1024;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid = 0, b_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] a_data = 0, b_data = 0, reg_wdata = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_rdata;
  logic a_ready, b_ready, irq, tx_clear;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_byte_buffer #(.DEPTH(DEPTH), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_clear(tx_clear)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    reg_addr = 3'd0; #1; d = reg_rdata; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push(bit chb, logic [7:0] d);
    if (chb) begin b_valid = 1; b_data = d; end
    else     begin a_valid = 1; a_data = d; end
    @(negedge clk); a_valid = 0; b_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    peek(3'd2, s);
    check("R1 reset status", s, 8'h01);
    check("R1 reset irq", irq, 0);
    check("R1 reset ready", {a_ready, b_ready}, 0);
    wreg(3'd1, 8'h01); push(0, 8'h12); push(0, 8'h13);
    wreg(3'd1, 8'h00); idle(1);
    peek(3'd2, s);
    check("R1 disable empties", s, 8'h01);
    check("R1 disabled ready", a_ready, 0);
  endtask

  task automatic t_source;
    logic [7:0] d, s;
    wreg(3'd1, 8'h03);
    check("R2 ready follows select", {a_ready, b_ready}, 2'b01);
    push(0, 8'h44);
    peek(3'd2, s);
    check("R2 other channel ignored", s[0], 1);
    push(1, 8'h55); pop(d);
    check("R2 channel B byte", d, 8'h55);
    wreg(3'd1, 8'h01);
    push(1, 8'h66); push(0, 8'h77); pop(d);
    check("R2 channel A byte", d, 8'h77);
  endtask

  task automatic t_order;
    logic [7:0] d;
    push(0, 8'hA1); push(0, 8'h00); push(0, 8'hFF);
    pop(d); check("R3 order 1", d, 8'hA1);
    pop(d); check("R3 order 2", d, 8'h00);
    pop(d); check("R3 order 3", d, 8'hFF);
  endtask

  task automatic t_empty_read;
    logic [7:0] d, s;
    pop(d); check("R4 empty read last byte", d, 8'hFF);
    pop(d); check("R4 repeat empty read", d, 8'hFF);
    peek(3'd2, s); check("R4 still empty", s[0], 1);
    push(0, 8'h33); pop(d);
    check("R4 pointer not moved", d, 8'h33);
  endtask

  task automatic t_fill;
    logic [7:0] s, d;
    wreg(3'd1, 8'h11);
    for (int i = 0; i < DEPTH/2 - 1; i++) push(0, 8'(i));
    peek(3'd2, s);
    check("R3 below half", s[1], 0);
    check("R8 no half irq yet", irq, 0);
    push(0, 8'(DEPTH/2 - 1));
    peek(3'd2, s);
    check("R3 half at DEPTH/2", s[1], 1);
    check("R8 half irq", irq, 1);
    for (int i = DEPTH/2; i < DEPTH; i++) push(0, 8'(i));
    peek(3'd2, s);
    check("R3 full flag", s[2], 1);
    check("R5 no overflow yet", s[3], 0);
    push(0, 8'hEE);
    peek(3'd2, s);
    check("R5 overflow set", s[3], 1);
    pop(d); check("R5 stored data kept", d, 8'h00);
    wreg(3'd1, 8'h51);
    peek(3'd2, s); check("R5 reset clears", s, 8'h01);
    peek(3'd1, s); check("R5 reset bit self-clears", s, 8'h11);
    wreg(3'd1, 8'h01);
  endtask

  task automatic t_pattern;
    logic [7:0] s, d;
    wreg(3'd3, 8'h7E); wreg(3'd4, 8'd3); wreg(3'd1, 8'h09);
    push(0, 8'h7E); push(0, 8'h11); push(0, 8'h7E);
    peek(3'd2, s); check("R6 two matches no event", s[4], 0);
    push(0, 8'h7E);
    peek(3'd2, s); check("R6 third match event", s[4], 1);
    check("R8 pattern irq", irq, 1);
    check("R8 half flag clear", s[1], 0);
    push(0, 8'h22);
    peek(3'd2, s); check("R8 event sticky", s[4], 1);
    pop(d);
    peek(3'd2, s); check("R8 read clears event", s[4], 0);
    push(0, 8'h7E); push(0, 8'h7E);
    peek(3'd2, s); check("R6 reload not early", s[4], 0);
    push(0, 8'h7E);
    peek(3'd2, s); check("R6 reload fires again", s[4], 1);
    wreg(3'd1, 8'h41); wreg(3'd1, 8'h01);
  endtask

  task automatic t_timeout;
    logic [7:0] s, d;
    wreg(3'd5, 8'd5); wreg(3'd1, 8'h05);
    idle(20);
    peek(3'd2, s); check("R7 empty never fires", s[5], 0);
    push(0, 8'h01); idle(4);
    peek(3'd2, s); check("R7 not before interval", s[5], 0);
    idle(3);
    peek(3'd2, s); check("R7 fires after idle", s[5], 1);
    check("R8 idle irq", irq, 1);
    pop(d);
    peek(3'd2, s); check("R8 read clears idle", s[5], 0);
    push(0, 8'h02); idle(3); push(0, 8'h03); idle(4);
    peek(3'd2, s); check("R7 restart on store", s[5], 0);
    idle(3);
    peek(3'd2, s); check("R7 fires after restart", s[5], 1);
    wreg(3'd1, 8'h41); wreg(3'd1, 8'h00);
  endtask

  task automatic t_txclear;
    logic [7:0] s;
    check("R9 idle low", tx_clear, 0);
    wreg(3'd1, 8'h81);
    check("R9 pulse", tx_clear, 1);
    idle(1);
    check("R9 pulse single", tx_clear, 0);
    peek(3'd1, s); check("R9 readback", s, 8'h01);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    t_reset(); t_source(); t_order(); t_empty_read();
    t_fill(); t_pattern(); t_timeout(); t_txclear();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule